// File: doc/BRIEF.md
# GPIO interrupt and wake aggregator

This block collects interrupt and wake events from a bank of general-purpose input pins and funnels them onto one shared interrupt line. Each pin has its own configuration word. That word selects whether the pin triggers on an edge or on a level and which polarity it uses. It also holds an interrupt enable, a delivery mask and three per-sleep-state wake enables. Two sticky status flags, one for interrupts and one for wakes, sit in the same word and are cleared by writing 1.

Software sees the bank through a flat word-addressed register space. Pin `i` lives at address `i`. The control word lives at address `NPINS`. The group summary follows at `NPINS+1` (low word) and `NPINS+2` (high word). Each summary bit ORs the pending flags of four neighbouring pins, so the handler only needs to inspect the groups that are flagged. The shared line stays high until software writes the end-of-interrupt bit, and it rises again if work is still pending.

A settle window protects against spurious events after a debounce change. When the window enable is set, changing any pin's debounce field stalls status capture on every pin for a programmed number of ticks. During that time the enable bits read back as 0.

Top module: `gpio_irq_wake_agg`

## Requirements
- R1: After reset every pin word, the control word, both summary words and `irq_out` read as 0.
- R2: In edge mode (pin word bit 2 = 0), the 2-bit field at bits 4:3 selects the trigger: 00 latches the interrupt status (bit 14) on a 0-to-1 input change, 01 on a 1-to-0 change, and 10 on either change. Latching requires the enable bit (bit 0) to be 1.
- R3: In level mode (bit 2 = 1), code 00 latches the status while the input is 1 and code 01 while it is 0. A write-1 clear issued while the level is still active leaves the status set; the same clear succeeds once the level has gone away.
- R4: Writing 1 to bit 14 or bit 15 of a pin word clears that status. Writing 0 to those bits leaves them unchanged.
- R5: With the enable bit at 0, no interrupt status is captured. A captured status drives `irq_out` only while both the enable bit and the mask bit (bit 1, where 1 allows delivery) are 1.
- R6: The wake status (bit 15) is captured on a trigger event only when the wake enable for the current `sleep_state` is 1: bit 5 for state 1, bit 6 for state 2, bit 7 for state 3. State 0 captures no wake status.
- R7: Summary bit g is 1 when any of pins 4g..4g+3 has bit 14 or bit 15 set. Bits 0-31 appear at address NPINS+1, and bits 32-45 appear at address NPINS+2, bits 13:0. Groups beyond 45 are never reported.
- R8: `irq_out` rises one cycle after an enabled, unmasked status is present. It stays high through status clears until a control write with bit 13 set. It drops on that write and rises again the next cycle if a deliverable status remains.
- R9: When the control bit 12 is 1, a pin write that changes its debounce field (bits 11:8) opens a window. During the window every pin's enable bit reads 0 and events are discarded, not held back.
- R10: The window lasts exactly the number of `tick` pulses programmed in control bits 11:0. Cycles without `tick` do not shorten it. With bit 12 at 0, or with a length of 0, no window opens.
- R11: A level-mode pin with code 10 never triggers, and code 11 never triggers in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPINS | Synchronised pin levels |
| sleep_state | input | 2 | 0 running, 1/2/3 selects a wake-enable bit |
| tick | input | 1 | Free-running time-base pulse for the settle window |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write word address |
| wr_data | input | 16 | Write data |
| rd_addr | input | AW | Read word address |
| rd_data | output | 32 | Combinational read data |
| irq_out | output | 1 | Shared interrupt line |

## Verification
The hardest case to reach is an input event that lands inside the settle window. Reaching it takes a configured pin, an armed control word, a debounce value that actually differs from the stored one, and an input toggle before enough ticks arrive. The bench holds `tick` low so the window stays open for as long as it needs. It then toggles the pin, reads the enable back as 0, and releases ticks one at a time to find the exact closing pulse. A second hard case is an end-of-interrupt that arrives while a status is still pending. The bench leaves the status set across the write so the one-cycle drop and the re-rise can both be observed.

// File: rtl/gpio_irq_wake_agg.sv
module gpio_irq_wake_agg #(
  parameter int NPINS = 16,
  localparam int NGRP = (NPINS + 3) / 4,
  localparam int AW   = $clog2(NPINS + 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [1:0]       sleep_state,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [15:0]      wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [31:0]      rd_data,
  output logic             irq_out
);
  localparam logic [AW-1:0] CTL_A = AW'(NPINS);
  localparam logic [AW-1:0] SLO_A = AW'(NPINS + 1);
  localparam logic [AW-1:0] SHI_A = AW'(NPINS + 2);

  logic [11:0]      cfg [NPINS];
  logic [NPINS-1:0] ists, wsts, pin_q, ev, wk_ok, sel, dbchg, en, msk;
  logic [11:0]      win_len, blk_cnt;
  logic             win_on, line_q;
  logic [4*NGRP-1:0] pend_pad;
  logic [63:0]      sum_w;

  wire ctl_wr   = wr_en && wr_addr == CTL_A;
  wire eoi_wr   = ctl_wr && wr_data[13];
  wire blocking = blk_cnt != '0;
  wire dbw      = |(sel & dbchg);
  wire any_del  = |((ists | wsts) & en & msk);
  assign irq_out = line_q;

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      sel[i]   = wr_en && wr_addr == AW'(i);
      dbchg[i] = wr_data[11:8] != cfg[i][11:8];
      en[i]    = cfg[i][0];
      msk[i]   = cfg[i][1];
      if (cfg[i][2])
        ev[i] = (cfg[i][4:3] == 2'd0) ? pin_in[i] :
                (cfg[i][4:3] == 2'd1) ? ~pin_in[i] : 1'b0;
      else
        case (cfg[i][4:3])
          2'd0:    ev[i] = pin_in[i] & ~pin_q[i];
          2'd1:    ev[i] = ~pin_in[i] & pin_q[i];
          2'd2:    ev[i] = pin_in[i] ^ pin_q[i];
          default: ev[i] = 1'b0;
        endcase
      wk_ok[i] = (sleep_state == 2'd1 && cfg[i][5]) ||
                 (sleep_state == 2'd2 && cfg[i][6]) ||
                 (sleep_state == 2'd3 && cfg[i][7]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPINS; i++) cfg[i] <= '0;
      ists <= '0; wsts <= '0; pin_q <= '0;
      win_len <= '0; win_on <= 1'b0; blk_cnt <= '0; line_q <= 1'b0;
    end else begin
      pin_q <= pin_in;
      for (int i = 0; i < NPINS; i++) begin
        if (sel[i]) cfg[i] <= wr_data[11:0];
        ists[i] <= (ists[i] & ~(sel[i] & wr_data[14])) | (ev[i] & en[i] & ~blocking);
        wsts[i] <= (wsts[i] & ~(sel[i] & wr_data[15])) | (ev[i] & wk_ok[i] & ~blocking);
      end
      if (ctl_wr) begin
        win_len <= wr_data[11:0];
        win_on  <= wr_data[12];
      end
      if (dbw && win_on)            blk_cnt <= win_len;
      else if (tick && blocking)    blk_cnt <= blk_cnt - 1'b1;
      if (eoi_wr)                   line_q <= 1'b0;
      else if (any_del)             line_q <= 1'b1;
    end
  end

  always_comb begin
    pend_pad = '0;
    pend_pad[NPINS-1:0] = ists | wsts;
    sum_w = '0;
    for (int g = 0; g < NGRP; g++)
      if (g < 46) sum_w[g] = |pend_pad[4*g +: 4];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NPINS; i++)
      if (rd_addr == AW'(i)) begin
        rd_data[11:0] = cfg[i];
        rd_data[0]    = cfg[i][0] & ~blocking;
        rd_data[14]   = ists[i];
        rd_data[15]   = wsts[i];
      end
    if (rd_addr == CTL_A) rd_data[12:0] = {win_on, win_len};
    if (rd_addr == SLO_A) rd_data = sum_w[31:0];
    if (rd_addr == SHI_A) rd_data = sum_w[63:32];
  end

  a_r8_eoi_drops: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |=> !irq_out);
  a_r8_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !eoi_wr) |=> irq_out);
  a_r5_rise_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(any_del));
  a_r9_window_drops: assert property (@(posedge clk) disable iff (!rst_n)
    blocking |=> (((ists | wsts) & ~($past(ists) | $past(wsts))) == '0));
  a_r10_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (blocking && !tick && !(dbw && win_on)) |=> $stable(blk_cnt));
endmodule

// File: tb/tb_gpio_irq_wake_agg.sv
`timescale 1ns/1ps
module tb_gpio_irq_wake_agg;
  localparam int NP = 16;
  localparam int AW = 5;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, irq_out;
  logic [NP-1:0] p = '0;
  logic [1:0] ss = '0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [31:0] rd_data, d;
  int checks = 0, fails = 0;
  bit done = 0;

  gpio_irq_wake_agg #(.NPINS(NP)) dut (.clk(clk), .rst_n(rst_n), .pin_in(p),
    .sleep_state(ss), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out));

  always #2.5 clk = ~clk;

  // {level, code[1:0], before, after, expected status}
  localparam logic [5:0] VEC [12] = '{
    6'b0_00_011, 6'b0_00_100, 6'b0_01_101, 6'b0_01_010,
    6'b0_10_011, 6'b0_10_101, 6'b1_00_011, 6'b1_00_100,
    6'b1_01_101, 6'b1_01_010, 6'b1_10_010, 6'b0_11_010};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask
  task automatic wr(input int a, input logic [15:0] v);
    @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(input int a, output logic [31:0] v);
    rd_addr = AW'(a); #1; v = rd_data;
  endtask
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary(); $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    rd(0, d);  chk("R1 pin word", d, 0);
    rd(NP, d); chk("R1 control", d, 0);
    rd(NP+1, d); chk("R1 summary", d, 0);
    chk("R1 irq", irq_out, 0);

    foreach (VEC[k]) begin
      automatic logic [5:0] v = VEC[k];
      automatic string tag = (v[4:3] == 2'd3 || (v[4:3] == 2'd2 && v[5])) ? "R11" : (v[5] ? "R3" : "R2");
      wr(0, 16'h0000); wr(0, 16'h4000);
      p[0] = v[2]; cyc(2);
      wr(0, 16'(v[4:3]) << 3 | 16'(v[5]) << 2 | 16'h1);
      p[0] = v[1]; cyc(2);
      rd(0, d); chk(tag, 32'(d[14]), 32'(v[0]));
    end
    wr(0, 0); wr(0, 16'h4000); p[0] = 0; cyc(2);

    // R3 clear while level active
    wr(0, 16'h0005); p[0] = 1; cyc(2);
    wr(0, 16'h4005); rd(0, d); chk("R3 clear held", 32'(d[14]), 1);
    p[0] = 0; wr(0, 16'h4005); rd(0, d); chk("R3 clear after", 32'(d[14]), 0);

    // R4 write-0 keeps, write-1 clears
    wr(0, 16'h0001); p[0] = 1; cyc(2);
    wr(0, 16'h0001); rd(0, d); chk("R4 keep", 32'(d[14]), 1);
    wr(0, 16'h4001); rd(0, d); chk("R4 clear", 32'(d[14]), 0);
    p[0] = 0; cyc(1);

    // R5 enable and mask
    wr(0, 16'h0000); p[0] = 1; cyc(2);
    rd(0, d); chk("R5 disabled", 32'(d[14]), 0);
    p[0] = 0; wr(0, 16'h0001); p[0] = 1; cyc(3);
    rd(0, d); chk("R5 captured", 32'(d[14]), 1);
    chk("R5 masked irq", irq_out, 0);
    wr(0, 16'h0003); chk("R8 delay", irq_out, 0);
    cyc(1); chk("R8 rise", irq_out, 1);
    wr(0, 16'h4003); cyc(1); chk("R8 held", irq_out, 1);
    wr(NP, 16'h2000); chk("R8 eoi drop", irq_out, 0);
    cyc(2); chk("R8 idle", irq_out, 0);
    p[0] = 0; cyc(1); p[0] = 1; cyc(3); chk("R8 new event", irq_out, 1);
    wr(NP, 16'h2000); chk("R8 eoi pending drop", irq_out, 0);
    cyc(1); chk("R8 reassert", irq_out, 1);
    wr(0, 16'h0000); wr(0, 16'h4000); wr(NP, 16'h2000); p[0] = 0; cyc(1);
    chk("R8 clean", irq_out, 0);

    // R6 wake per state
    wr(1, 16'h0040); ss = 2'd0; p[1] = 1; cyc(2);
    rd(1, d); chk("R6 state0", 32'(d[15]), 0);
    p[1] = 0; wr(1, 16'h0020); ss = 2'd2; p[1] = 1; cyc(2);
    rd(1, d); chk("R6 wrong state", 32'(d[15]), 0);
    p[1] = 0; wr(1, 16'h0040); p[1] = 1; cyc(2);
    rd(1, d); chk("R6 match", 32'(d[15]), 1);
    chk("R6 no irq", irq_out, 0);
    wr(1, 16'h8000); rd(1, d); chk("R4 wake clear", 32'(d[15]), 0);
    ss = 2'd0; p[1] = 0; cyc(1);

    // R7 summary
    wr(5, 16'h0001); wr(13, 16'h0001); p[5] = 1; p[13] = 1; cyc(2);
    rd(NP+1, d); chk("R7 low word", d, 32'hA);
    rd(NP+2, d); chk("R7 high word", d, 0);
    wr(5, 16'h4000); wr(13, 16'h4000);
    rd(NP+1, d); chk("R7 cleared", d, 0);

    // R9 / R10 window
    wr(2, 16'h0001); wr(NP, 16'h1003);
    wr(2, 16'h0501); rd(2, d); chk("R9 enable reads 0", 32'(d[0]), 0);
    p[2] = 1; cyc(2); rd(2, d); chk("R9 event dropped", 32'(d[14]), 0);
    cyc(10); rd(2, d); chk("R10 no tick", 32'(d[0]), 0);
    repeat (2) begin tick = 1; cyc(1); tick = 0; end
    rd(2, d); chk("R10 two ticks", 32'(d[0]), 0);
    tick = 1; cyc(1); tick = 0;
    rd(2, d); chk("R10 third tick", 32'(d[0]), 1);
    chk("R9 no deferred event", 32'(d[14]), 0);
    p[2] = 0; cyc(1); p[2] = 1; cyc(2);
    rd(2, d); chk("R9 after window", 32'(d[14]), 1);
    wr(NP, 16'h0003); wr(2, 16'h0601); rd(2, d); chk("R10 window off", 32'(d[0]), 1);
    wr(NP, 16'h1000); wr(2, 16'h0701); rd(2, d); chk("R10 zero length", 32'(d[0]), 1);

    done = 1;
    summary();
    $finish;
  end
endmodule